// File: doc/BRIEF.md
# Time-Slot Switch Processor Port

This block is the 8-bit host-side access port of a time-slot interchange switch. A host sees only a small address window: six address lines, a chip select, a data strobe and a read/write line. The port returns an active-low acknowledge when each transfer is done. One byte of the window is the mode register. The other 32 bytes form a channel window whose meaning comes from that register. Its stream field picks one of eight serial streams. Its memory-select field picks the receive data memory, the low connection memory (source address or fixed output byte) or the high connection memory (per-channel control bits).

Mode register accesses finish one clock after the strobe is seen. Memory accesses are paced by the serial clock. The port waits a fixed number of clocks, then waits for a free memory slot that the timing unit grants, then makes one memory operation. For a read it captures the data a clock later and then acknowledges. The memories are outside the block. The port drives their address (stream in the upper bits, channel in the lower), write data and per-memory read and write strobes, and it exports the global processor-output bit to the datapath.

Top module: `tsi_cpu_port`

## Requirements
- R1: With addr[5]=0, an access reaches the mode register whatever addr[4:0] hold, and ack_n goes low one clock after the strobe (cs_n low and ds high) is first sampled.
- R2: After reset the mode register reads 0x00, proc_en is 0 and ack_n is high.
- R3: With addr[5]=1, the memory address is {mode[2:0], addr[4:0]}, so each stream has its own 32 bytes. With the slot free, ack_n goes low SYNC_CYC+4 clocks (6 by default) after the strobe is first sampled.
- R4: With mode[4:3]=10 and mode[7]=0, the channel window reads and writes the low connection memory.
- R5: With mode[4:3]=11 and mode[7]=0, writes store only wdata[2:0] in the high connection memory, and reads return those bits with bits 7..3 zero.
- R6: With mode[4:3]=01 and mode[7]=0, reads return the data memory and writes change no memory but are still acknowledged.
- R7: With mode[4:3]=00 and mode[7]=0, reads return 0x00 and writes change no memory. Both are acknowledged with the normal memory latency.
- R8: With mode[7]=1, channel-window reads come from the data memory and writes go to the low connection memory, whatever mode[4:3] hold.
- R9: A memory access waits while slot_free is low, and its acknowledge is delayed by one clock for each such cycle.
- R10: ack_n stays low while the strobe is held, and it returns high one clock after the strobe is removed.
- R11: If the strobe is removed before the memory slot is taken, the access is dropped. No memory is written and no acknowledge is given.
- R12: proc_en follows mode[6]. Mode bit 5 has no storage and reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; also paces host accesses |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Bit 5 picks the channel window; bits 4..0 pick the channel |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid while ack_n is low |
| ack_n | output | 1 | Transfer acknowledge, active low |
| slot_free | input | 1 | Memory slot grant from the timing unit |
| mem_addr | output | 8 | Memory address {stream, channel} |
| mem_wdata | output | 8 | Memory write data |
| dm_rd | output | 1 | Data memory read strobe |
| cml_rd | output | 1 | Low connection memory read strobe |
| cmh_rd | output | 1 | High connection memory read strobe |
| cml_we | output | 1 | Low connection memory write enable |
| cmh_we | output | 1 | High connection memory write enable |
| dm_rdata | input | 8 | Data memory read data, one clock after dm_rd |
| cml_rdata | input | 8 | Low connection memory read data, one clock after cml_rd |
| cmh_rdata | input | 3 | High connection memory read data, one clock after cmh_rd |
| proc_en | output | 1 | Global processor-output mode bit |

## Verification
The hardest cases to reach are a host that gives up before the slot is granted and an access that sits for many cycles waiting for a slot. The bench holds slot_free low through the synchronising cycles. It then either removes the strobe while the port is still waiting, and reads the target location back to show it is unchanged, or it releases the grant at a chosen cycle and checks that the acknowledge is late by exactly that many cycles. The split and reserved modes are set up by giving the mode register select codes that conflict with the memory that the access then reaches.

// File: rtl/tsi_port_pkg.sv
package tsi_port_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_SLOT, ST_XFER, ST_FETCH, ST_HOLD
  } seq_state_t;

  typedef enum logic [1:0] {TG_NONE, TG_DM, TG_CML, TG_CMH} tgt_t;

  localparam logic [1:0] SEL_DM  = 2'b01;
  localparam logic [1:0] SEL_CML = 2'b10;
  localparam logic [1:0] SEL_CMH = 2'b11;
endpackage

// File: rtl/tsi_ctrl_reg.sv
module tsi_ctrl_reg #(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] KEEP_MASK = 8'hDF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q
);
  logic [DW-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) ctrl_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/tsi_tgt_dec.sv
module tsi_tgt_dec
  import tsi_port_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SPLIT_BIT = 7,
  parameter int SEL_HI    = 4
) (
  input  logic [DW-1:0] ctrl_q,
  input  logic          rw_n,
  output tgt_t          tgt
);
  logic [1:0] sel;

  always_comb begin
    sel = ctrl_q[SEL_HI -: 2];
    tgt = TG_NONE;
    if (ctrl_q[SPLIT_BIT]) begin
      tgt = rw_n ? TG_DM : TG_CML;
    end else begin
      unique case (sel)
        SEL_DM:  tgt = rw_n ? TG_DM : TG_NONE;
        SEL_CML: tgt = TG_CML;
        SEL_CMH: tgt = TG_CMH;
        default: tgt = TG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tsi_access_seq.sv
module tsi_access_seq
  import tsi_port_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CHW      = 5,
  parameter int STW      = 3,
  parameter int CMHW     = 3,
  parameter int SYNC_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             rw_n,
  input  logic             win_sel,
  input  logic [CHW-1:0]   chan,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    ctrl_q,
  input  logic [STW-1:0]   stream,
  input  tgt_t             tgt,
  input  logic             slot_free,
  input  logic [DW-1:0]    dm_rdata,
  input  logic [DW-1:0]    cml_rdata,
  input  logic [CMHW-1:0]  cmh_rdata,
  output logic             ctrl_we,
  output logic [DW-1:0]    rdata,
  output logic             ack_n,
  output logic [STW+CHW-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             dm_rd,
  output logic             cml_rd,
  output logic             cmh_rd,
  output logic             cml_we,
  output logic             cmh_we
);
  localparam int MAW  = STW + CHW;
  localparam int CNTW = $clog2(SYNC_CYC + 1);
  localparam logic [CNTW-1:0] CNT_LOAD = CNTW'(SYNC_CYC - 1);

  seq_state_t     state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  tgt_t           tgt_q, tgt_d;
  logic           rw_q, rw_d;
  logic [MAW-1:0] addr_q, addr_d;
  logic [DW-1:0]  wd_q, wd_d;
  logic [DW-1:0]  rd_q, rd_d;
  logic           in_xfer;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tgt_d   = tgt_q;
    rw_d    = rw_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    rd_d    = rd_q;
    ctrl_we = 1'b0;
    unique case (state_q)
      ST_IDLE: if (strobe) begin
        if (!win_sel) begin
          ctrl_we = !rw_n;
          rd_d    = ctrl_q;
          state_d = ST_HOLD;
        end else begin
          tgt_d   = tgt;
          rw_d    = rw_n;
          addr_d  = {stream, chan};
          wd_d    = wdata;
          cnt_d   = CNT_LOAD;
          state_d = ST_SYNC;
        end
      end
      ST_SYNC: begin
        if (!strobe)            state_d = ST_IDLE;
        else if (cnt_q == '0)   state_d = ST_SLOT;
        else                    cnt_d   = cnt_q - 1'b1;
      end
      ST_SLOT: begin
        if (!strobe)            state_d = ST_IDLE;
        else if (slot_free)     state_d = ST_XFER;
      end
      ST_XFER:  state_d = ST_FETCH;
      ST_FETCH: begin
        if (rw_q) begin
          unique case (tgt_q)
            TG_DM:   rd_d = dm_rdata;
            TG_CML:  rd_d = cml_rdata;
            TG_CMH:  rd_d = {{(DW-CMHW){1'b0}}, cmh_rdata};
            default: rd_d = '0;
          endcase
        end
        state_d = ST_HOLD;
      end
      ST_HOLD: if (!strobe) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tgt_q   <= TG_NONE;
      rw_q    <= 1'b1;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tgt_q   <= tgt_d;
      rw_q    <= rw_d;
      addr_q  <= addr_d;
      wd_q    <= wd_d;
      rd_q    <= rd_d;
    end
  end

  assign in_xfer   = (state_q == ST_XFER);
  assign dm_rd     = in_xfer &&  rw_q && (tgt_q == TG_DM);
  assign cml_rd    = in_xfer &&  rw_q && (tgt_q == TG_CML);
  assign cmh_rd    = in_xfer &&  rw_q && (tgt_q == TG_CMH);
  assign cml_we    = in_xfer && !rw_q && (tgt_q == TG_CML);
  assign cmh_we    = in_xfer && !rw_q && (tgt_q == TG_CMH);
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign rdata     = rd_q;
  assign ack_n     = (state_q != ST_HOLD);
endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
  import tsi_port_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CHW      = 5,
  parameter int STW      = 3,
  parameter int CMHW     = 3,
  parameter int SYNC_CYC = 2,
  parameter int PE_BIT   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                ds,
  input  logic                rw_n,
  input  logic [CHW:0]        addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic                ack_n,
  input  logic                slot_free,
  output logic [STW+CHW-1:0]  mem_addr,
  output logic [DW-1:0]       mem_wdata,
  output logic                dm_rd,
  output logic                cml_rd,
  output logic                cmh_rd,
  output logic                cml_we,
  output logic                cmh_we,
  input  logic [DW-1:0]       dm_rdata,
  input  logic [DW-1:0]       cml_rdata,
  input  logic [CMHW-1:0]     cmh_rdata,
  output logic                proc_en
);
  logic          strobe;
  logic          ctrl_we;
  logic [DW-1:0] ctrl_q;
  tgt_t          tgt;

  assign strobe  = !cs_n && ds;
  assign proc_en = ctrl_q[PE_BIT];

  tsi_ctrl_reg #(.DW(DW), .KEEP_MASK(8'hDF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(wdata), .ctrl_q(ctrl_q)
  );

  tsi_tgt_dec #(.DW(DW)) u_dec (
    .ctrl_q(ctrl_q), .rw_n(rw_n), .tgt(tgt)
  );

  tsi_access_seq #(
    .DW(DW), .CHW(CHW), .STW(STW), .CMHW(CMHW), .SYNC_CYC(SYNC_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rw_n(rw_n),
    .win_sel(addr[CHW]), .chan(addr[CHW-1:0]), .wdata(wdata),
    .ctrl_q(ctrl_q), .stream(ctrl_q[STW-1:0]), .tgt(tgt),
    .slot_free(slot_free), .dm_rdata(dm_rdata), .cml_rdata(cml_rdata),
    .cmh_rdata(cmh_rdata), .ctrl_we(ctrl_we), .rdata(rdata), .ack_n(ack_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dm_rd(dm_rd),
    .cml_rd(cml_rd), .cmh_rd(cmh_rd), .cml_we(cml_we), .cmh_we(cmh_we)
  );
endmodule

// File: rtl/tsi_cpu_port_chk.sv
module tsi_cpu_port_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ds,
  input logic          rw_n,
  input logic [AW-1:0] addr,
  input logic          ack_n,
  input logic          slot_free,
  input logic          dm_rd,
  input logic          cml_rd,
  input logic          cmh_rd,
  input logic          cml_we,
  input logic          cmh_we,
  input logic          proc_en
);
  logic stb;
  logic any_op;
  assign stb    = !cs_n && ds;
  assign any_op = dm_rd || cml_rd || cmh_rd || cml_we || cmh_we;

  a_r2_ack_high_in_reset: assert property (@(posedge clk)
    !rst_n |-> ack_n);

  a_r1_fast_mode_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stb) && !addr[AW-1]) |=> !ack_n);

  a_r10_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !stb) |=> ack_n);

  a_r9_op_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    any_op |-> $past(slot_free));

  a_r3_single_mem_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dm_rd, cml_rd, cmh_rd, cml_we, cmh_we}));

  a_r12_pe_only_by_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb && !rw_n && !addr[AW-1]) |-> $stable(proc_en));
endmodule

bind tsi_cpu_port tsi_cpu_port_chk #(.AW(6)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rw_n(rw_n), .addr(addr),
  .ack_n(ack_n), .slot_free(slot_free), .dm_rd(dm_rd), .cml_rd(cml_rd),
  .cmh_rd(cmh_rd), .cml_we(cml_we), .cmh_we(cmh_we), .proc_en(proc_en)
);

// File: tb/tsi_cpu_port_tb_top.sv
`timescale 1ns/1ps
module tsi_cpu_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ds = 1'b0, rw_n = 1'b1, slot_free = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, mem_addr, mem_wdata;
  logic       ack_n, dm_rd, cml_rd, cmh_rd, cml_we, cmh_we, proc_en;
  logic [7:0] dm_q = '0, cml_q = '0;
  logic [2:0] cmh_q = '0;
  logic [7:0] cml_m [256];
  logic [2:0] cmh_m [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tsi_cpu_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds(ds), .rw_n(rw_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .slot_free(slot_free),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dm_rd(dm_rd), .cml_rd(cml_rd),
    .cmh_rd(cmh_rd), .cml_we(cml_we), .cmh_we(cmh_we), .dm_rdata(dm_q),
    .cml_rdata(cml_q), .cmh_rdata(cmh_q), .proc_en(proc_en)
  );

  function automatic logic [7:0] dm_val(input logic [7:0] a);
    return a * 8'd7 + 8'h31;
  endfunction

  // Memory models: synchronous read, one clock latency.
  always @(posedge clk) begin
    if (dm_rd)  dm_q  <= dm_val(mem_addr);
    if (cml_rd) cml_q <= cml_m[mem_addr];
    if (cmh_rd) cmh_q <= cmh_m[mem_addr];
    if (cml_we) cml_m[mem_addr] <= mem_wdata;
    if (cmh_we) cmh_m[mem_addr] <= mem_wdata[2:0];
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One host transfer. stall: slot_free is held low until that many cycles
  // have been counted. hold: extra cycles the strobe stays after ack.
  task automatic bus_xfer(input string req, input logic rw, input logic [5:0] a,
                          input logic [7:0] d, input int stall, input int hold,
                          output logic [7:0] q, output int lat);
    @(negedge clk);
    cs_n = 1'b0; ds = 1'b1; rw_n = rw; addr = a; wdata = d;
    slot_free = (stall == 0);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat >= stall) slot_free = 1'b1;
    end while (ack_n && lat < 200);
    q = rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(req, "ack held with strobe", ack_n, 0);
      chk(req, "read data stable", rdata, q);
    end
    cs_n = 1'b1; ds = 1'b0;
    if (hold > 0) begin
      @(negedge clk);
      chk(req, "ack released", ack_n, 1);
    end
  endtask

  // {rw, addr, wdata, expected read, expected latency}
  localparam int NV = 28;
  localparam logic [26:0] TBL [NV] = '{
    {1'b0, 6'h05, 8'h13, 8'h00, 4'd1},  // R1 mode write, low bits ignored
    {1'b1, 6'h1F, 8'h00, 8'h13, 4'd1},  // R1 mode read
    {1'b0, 6'h27, 8'hA5, 8'h00, 4'd6},  // R4 CML stream3 ch7
    {1'b1, 6'h27, 8'h00, 8'hA5, 4'd6},  // R4
    {1'b0, 6'h00, 8'h0B, 8'h00, 4'd1},  // R6 select DM stream3
    {1'b1, 6'h27, 8'h00, 8'h02, 4'd6},  // R6 DM read
    {1'b0, 6'h27, 8'hFF, 8'h00, 4'd6},  // R6 DM write ignored
    {1'b1, 6'h27, 8'h00, 8'h02, 4'd6},  // R6
    {1'b0, 6'h00, 8'h1D, 8'h00, 4'd1},  // R5 select CMH stream5
    {1'b0, 6'h22, 8'hFE, 8'h00, 4'd6},  // R5
    {1'b1, 6'h22, 8'h00, 8'h06, 4'd6},  // R5 upper bits zero
    {1'b0, 6'h00, 8'h8B, 8'h00, 4'd1},  // R8 split, select says DM
    {1'b1, 6'h27, 8'h00, 8'h02, 4'd6},  // R8 read from DM
    {1'b0, 6'h27, 8'h3C, 8'h00, 4'd6},  // R8 write to CML
    {1'b0, 6'h00, 8'h13, 8'h00, 4'd1},  // R8
    {1'b1, 6'h27, 8'h00, 8'h3C, 4'd6},  // R8
    {1'b0, 6'h00, 8'h03, 8'h00, 4'd1},  // R7 reserved select
    {1'b1, 6'h27, 8'h00, 8'h00, 4'd6},  // R7 reads zero
    {1'b0, 6'h27, 8'h77, 8'h00, 4'd6},  // R7 write dropped
    {1'b0, 6'h00, 8'h13, 8'h00, 4'd1},  // R7
    {1'b1, 6'h27, 8'h00, 8'h3C, 4'd6},  // R7
    {1'b0, 6'h00, 8'h73, 8'h00, 4'd1},  // R12 bit5 not stored
    {1'b1, 6'h00, 8'h00, 8'h53, 4'd1},  // R12
    {1'b0, 6'h00, 8'h15, 8'h00, 4'd1},  // R3 CML stream5
    {1'b1, 6'h27, 8'h00, 8'h00, 4'd6},  // R3 separate section
    {1'b0, 6'h27, 8'h11, 8'h00, 4'd6},  // R3
    {1'b0, 6'h00, 8'h13, 8'h00, 4'd1},  // R3 back to stream3
    {1'b1, 6'h27, 8'h00, 8'h3C, 4'd6}   // R3 stream3 untouched
  };

  function automatic string req_of(input int i);
    if (i < 2)  return "R1";
    if (i < 4)  return "R4";
    if (i < 8)  return "R6";
    if (i < 11) return "R5";
    if (i < 16) return "R8";
    if (i < 21) return "R7";
    if (i < 23) return "R12";
    return "R3";
  endfunction

  initial begin
    logic [7:0] q;
    int lat;
    for (int i = 0; i < 256; i++) begin cml_m[i] = '0; cmh_m[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R2", "ack_n in reset", ack_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "ack_n after reset", ack_n, 1);
    chk("R2", "proc_en after reset", proc_en, 0);
    bus_xfer("R2", 1'b1, 6'h00, 8'h00, 0, 0, q, lat);
    chk("R2", "mode reset value", q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = TBL[i];
      bus_xfer(req_of(i), v[26], v[25:20], v[19:12], 0, 0, q, lat);
      chk(req_of(i), $sformatf("vec %0d latency", i), lat, int'(v[3:0]));
      if (v[26]) chk(req_of(i), $sformatf("vec %0d rdata", i), q, v[11:4]);
    end

    // R12: proc_en follows mode bit 6
    bus_xfer("R12", 1'b0, 6'h00, 8'h40, 0, 0, q, lat);
    @(negedge clk);
    chk("R12", "proc_en set", proc_en, 1);
    bus_xfer("R12", 1'b0, 6'h00, 8'h13, 0, 0, q, lat);
    @(negedge clk);
    chk("R12", "proc_en clear", proc_en, 0);

    // R9: slot withheld until cycle 7 -> four extra cycles
    bus_xfer("R9", 1'b1, 6'h27, 8'h00, 7, 0, q, lat);
    chk("R9", "stalled latency", lat, 10);
    chk("R9", "stalled rdata", q, 8'h3C);

    // R10: strobe held after ack
    bus_xfer("R10", 1'b1, 6'h27, 8'h00, 0, 3, q, lat);
    chk("R10", "held read data", q, 8'h3C);
    bus_xfer("R10", 1'b1, 6'h00, 8'h00, 0, 2, q, lat);
    chk("R10", "held mode read", q, 8'h13);

    // R11: strobe dropped while waiting for the slot
    @(negedge clk);
    slot_free = 1'b0;
    cs_n = 1'b0; ds = 1'b1; rw_n = 1'b0; addr = 6'h27; wdata = 8'h99;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11", "no ack while waiting", ack_n, 1);
    end
    cs_n = 1'b1; ds = 1'b0;
    @(negedge clk);
    slot_free = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11", "no ack after abort", ack_n, 1);
    end
    bus_xfer("R11", 1'b1, 6'h27, 8'h00, 0, 0, q, lat);
    chk("R11", "location unchanged", q, 8'h3C);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule